// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol engine of a byte-addressed serial memory that sits on a two-wire open-drain bus. A fast system clock oversamples the clock line and the data line through two-flop synchronizers. The block finds the bus start and stop conditions and decodes the device-select byte. It then moves bytes between the bus and a simple internal memory port. The data line is driven only low, through an output enable. A pull-up outside the block supplies the high level.

The device-select byte that follows a start carries three fields. Bits 7:4 hold a fixed device code. Bits 3:1 select one 256-byte page, and that page forms the upper pointer bits. Bit 0 gives the direction: 0 for a write, 1 for a read. A write names a byte within the page and then streams data bytes, each presented once on the memory port. A read streams bytes from the pointer, and the pointer advances after each byte. A read that begins with a repeated start after the address phase is a random read. A read with no address phase continues from the pointer's last value.

The state machine has ten named states. IDLE waits for a start. DEVSEL shifts in the device-select byte. DEVSEL_ACK acknowledges it. WORD shifts in the in-page byte address. WORD_ACK acknowledges it. WDATA shifts in a write byte. WDATA_ACK acknowledges it. RDATA shifts out a read byte. RD_ACK samples the master's acknowledge. PARK stays silent until the next start or stop. The transitions are:
- A start moves any state to DEVSEL, and a stop moves any state to IDLE.
- DEVSEL goes to DEVSEL_ACK after 8 bits when the code matches, and to PARK when it does not.
- DEVSEL_ACK goes to WORD for a write and to RDATA for a read, at the falling clock edge that ends the ninth bit.
- WORD goes to WORD_ACK, and WORD_ACK goes to WDATA.
- WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA.
- RDATA goes to RD_ACK after the eighth falling edge.
- RD_ACK goes to RDATA when the master acknowledges and to PARK on a not-acknowledge.

Top module: `i2c_mem_slave`

## Requirements
- R1: A start condition (data falling while the clock line is high) is honoured in every state. It abandons a partly received byte without a memory write and begins a new device-select phase.
- R2: A stop condition (data rising while the clock line is high) returns the block to IDLE and releases the data line. Reset leaves the data line released and the memory port quiet.
- R3: The block acknowledges a device-select byte only when its bits 7:4 equal 1010, by pulling data low for the ninth clock. On a mismatch it never drives the line and issues no memory access until the next start.
- R4: On an acknowledged write select, the pointer takes bits 3:1 of the select byte as address bits 10:8. The following byte is acknowledged and becomes address bits 7:0.
- R5: Each further byte received in a write is acknowledged and presented once on the memory port with its address and data. The pointer then advances by one.
- R6: Read data leaves most significant bit first and changes only after a falling clock edge. A read select with no address phase starts at the current pointer, and its page bits are ignored.
- R7: A random read consists of a write select, a word byte, a repeated start and a read select. It returns the byte at the address that was set.
- R8: The pointer advances after each byte that is sent. An acknowledge from the master fetches the next byte. The pointer wraps from 7FF to 000, for reads and writes alike.
- R9: On a not-acknowledge from the master, the block releases the data line and stays silent through any further clocks until a start or stop.
- R10: A read strobe lasts one system clock, and read data is taken on the following clock. Read and write strobes never coincide.
- R11: The output enable only ever rises while the synchronized clock line is low. It is never asserted while the master owns a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | When high, pull the data line low |
| mem_addr | output | 11 | Memory address, equal to the pointer |
| mem_wdata | output | 8 | Write data, valid with mem_we |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, sampled the clock after mem_re |

## Verification
The bench targets these cases:
- Wrap from 7FF to 000. A pointer that does not wrap, or that carries into a page bit, would write or read the wrong bytes.
- Repeated start during a half-received data byte. A design that committed partial bytes would emit an unexpected write strobe, and one that lost the pointer would return the wrong byte.
- A device-select byte with the wrong code. A design that decoded too few bits would acknowledge it, or write memory, where the bench expects silence.
- A current-address read whose select byte carries unrelated page bits. A design that loaded those bits would read from the wrong page.
- Clocks sent after a not-acknowledge. A design that kept driving during them would pull the line low while the master owns it.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_DEVSEL_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_PARK
    } slv_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_ff;
    logic [LAST:0] sda_ff;
    logic          scl_q;
    logic          sda_q;

    // One synchronizer chain per line; the idle bus level is high.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_ff[g] <= scl_i;
                    sda_ff[g] <= sda_i;
                end else begin
                    scl_ff[g] <= scl_ff[(g == 0) ? 0 : g - 1];
                    sda_ff[g] <= sda_ff[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[LAST];
    assign sda_s = sda_ff[LAST];

    // Keep the previous sample of each line so that edges can be seen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // Data may only move while the clock is high when it is a bus condition.
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             bit_in,
    output logic [WIDTH-1:0] data,
    output logic             last
);

    localparam int unsigned CNT_W = $clog2(WIDTH);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clear) begin
            cnt  <= '0;
        end else if (sample) begin
            data <= {data[WIDTH-2:0], bit_in};
            cnt  <= (cnt == CNT_W'(WIDTH - 1)) ? '0 : cnt + 1'b1;
        end
    end

    // High while the next sample completes a byte.
    assign last = (cnt == CNT_W'(WIDTH - 1));

endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic [ADDR_W-9:0] hi_val,
    input  logic              load_lo,
    input  logic [7:0]        lo_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end else begin
            if (load_hi) ptr[ADDR_W-1:8] <= hi_val;
            if (load_lo) ptr[7:0]        <= lo_val;
        end
    end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter logic [3:0]  DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);

    localparam int unsigned PAGE_W = ADDR_W - 8;

    slv_state_e state;
    slv_state_e state_n;

    logic        scl_s;
    logic        sda_s;
    logic        scl_rise;
    logic        scl_fall;
    logic        start_det;
    logic        stop_det;

    logic [7:0]  rx_data;
    logic        rx_last;
    logic [7:0]  rx_byte;
    logic        rx_sample;
    logic        byte_done;
    logic        code_ok;

    logic        ack_drv;
    logic        ack_half;
    logic        dir_rd;
    logic [7:0]  tx_sh;
    logic [2:0]  tx_cnt;
    logic        rd_pend;

    logic        ptr_load_hi;
    logic        ptr_load_lo;
    logic        ptr_inc;
    logic        tx_last_fall;

    i2c_line_cond #(.SYNC_STAGES(2)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign rx_sample = scl_rise &&
                       (state == ST_DEVSEL || state == ST_WORD || state == ST_WDATA);

    i2c_byte_rx #(.WIDTH(BYTE_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_det),
        .sample (rx_sample),
        .bit_in (sda_s),
        .data   (rx_data),
        .last   (rx_last)
    );

    assign rx_byte      = {rx_data[6:0], sda_s};
    assign byte_done    = rx_sample && rx_last;
    assign code_ok      = (rx_byte[7:4] == DEV_CODE);
    assign tx_last_fall = (state == ST_RDATA) && scl_fall && (tx_cnt == 3'd7);

    assign ptr_load_hi = (state == ST_DEVSEL) && byte_done && code_ok && !rx_byte[0];
    assign ptr_load_lo = (state == ST_WORD) && byte_done;
    assign ptr_inc     = mem_we | tx_last_fall;

    i2c_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (ptr_load_hi),
        .hi_val  (rx_byte[PAGE_W:1]),
        .load_lo (ptr_load_lo),
        .lo_val  (rx_byte),
        .inc     (ptr_inc),
        .ptr     (mem_addr)
    );

    // Next-state logic: bus conditions win over everything else.
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_DEVSEL;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       state_n = ST_IDLE;
                ST_DEVSEL:     if (byte_done) state_n = code_ok ? ST_DEVSEL_ACK : ST_PARK;
                ST_DEVSEL_ACK: if (scl_fall && ack_half) state_n = dir_rd ? ST_RDATA : ST_WORD;
                ST_WORD:       if (byte_done) state_n = ST_WORD_ACK;
                ST_WORD_ACK:   if (scl_fall && ack_half) state_n = ST_WDATA;
                ST_WDATA:      if (byte_done) state_n = ST_WDATA_ACK;
                ST_WDATA_ACK:  if (scl_fall && ack_half) state_n = ST_WDATA;
                ST_RDATA:      if (tx_last_fall) state_n = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && sda_s)           state_n = ST_PARK;
                    else if (scl_fall && ack_half)   state_n = ST_RDATA;
                end
                ST_PARK:       state_n = ST_PARK;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_drv   <= 1'b0;
            ack_half  <= 1'b0;
            dir_rd    <= 1'b0;
            tx_sh     <= '0;
            tx_cnt    <= '0;
            rd_pend   <= 1'b0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            mem_wdata <= '0;
        end else begin
            mem_we  <= 1'b0;
            mem_re  <= 1'b0;
            rd_pend <= mem_re;
            if (start_det || stop_det) begin
                ack_drv  <= 1'b0;
                ack_half <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVSEL: begin
                        if (byte_done && code_ok) begin
                            dir_rd <= rx_byte[0];
                            mem_re <= rx_byte[0];
                        end
                    end
                    ST_DEVSEL_ACK, ST_WORD_ACK, ST_WDATA_ACK: begin
                        // First fall: start pulling; second fall: let go.
                        if (scl_fall) begin
                            ack_drv  <= !ack_half;
                            ack_half <= !ack_half;
                        end
                    end
                    ST_WDATA: begin
                        if (byte_done) begin
                            mem_we    <= 1'b1;
                            mem_wdata <= rx_byte;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall && tx_cnt != 3'd7) begin
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            tx_cnt <= tx_cnt + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise && !sda_s) begin
                            ack_half <= 1'b1;
                            mem_re   <= 1'b1;
                        end else if (scl_fall) begin
                            ack_half <= 1'b0;
                        end
                    end
                    ST_IDLE, ST_WORD, ST_PARK: begin
                        ack_drv  <= 1'b0;
                        ack_half <= 1'b0;
                    end
                endcase
            end
            if (rd_pend) begin
                tx_sh  <= mem_rdata;
                tx_cnt <= '0;
            end
        end
    end

    // Output decode: acknowledge pull, or a zero bit of read data.
    always_comb begin
        sda_oe = ack_drv;
        if (state == ST_RDATA && !tx_sh[7]) sda_oe = 1'b1;
    end

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
    import i2c_mem_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input slv_state_e        state
);

    // R1
    p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_DEVSEL);

    // R2
    p_stop_idles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R5
    p_write_bumps_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    // R9
    p_park_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PARK |-> !sda_oe);

    // R10
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R10
    p_re_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    // R11
    p_oe_rise_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .state     (state)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata = '0;
    logic        sda_bus;
    logic        master_owns = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int we_count = 0;
    int ref_ptr = 0;

    logic [7:0]  ext_mem [0:2047];
    logic [7:0]  ref_mem [0:2047];
    logic [18:0] exp_wq [$];

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_mem_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Memory environment and per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
        if (rst_n) begin
            if (master_owns) check("R11", sda_oe, 0, "drive during master bit");
            if (mem_we && mem_re) check("R10", 1, 0, "strobes together");
            if (mem_we) begin
                we_count++;
                if (exp_wq.size() == 0) begin
                    check("R5", {mem_addr, mem_wdata}, 0, "unexpected write");
                end else begin
                    check("R5", {mem_addr, mem_wdata}, exp_wq.pop_front(), "write addr/data");
                end
                ext_mem[mem_addr] = mem_wdata;
            end
            if (mem_re) mem_rdata <= ext_mem[mem_addr];
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b0; wait_clks(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b1; wait_clks(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_clks(H);
        scl_m = 1'b1; master_owns = 1'b1; wait_clks(H);
        master_owns = 1'b0; scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_clks(H);
        scl_m = 1'b1; wait_clks(H / 2);
        b = sda_bus; wait_clks(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        send_bit(!mack);
    endtask

    task automatic expect_write(input int addr, input logic [7:0] d);
        exp_wq.push_back({11'(addr), d});
        ref_mem[addr] = d;
    endtask

    logic       ack;
    logic [7:0] rb;
    int         we_before;

    initial begin
        for (int i = 0; i < 2048; i++) begin
            ext_mem[i] = 8'(i) ^ 8'h5A ^ {5'b0, 3'(i >> 8)};
            ref_mem[i] = ext_mem[i];
        end
        wait_clks(5);
        check("R2", sda_oe, 0, "reset oe");
        check("R10", {mem_we, mem_re}, 0, "reset strobes");
        rst_n = 1'b1;
        wait_clks(4);

        // Write two bytes to page 3, word 45 (R3, R4, R5).
        bus_start();
        send_byte(8'hA6, ack); check("R3", ack, 0, "select ack");
        send_byte(8'h45, ack); check("R4", ack, 0, "word ack");
        expect_write(12'h345, 8'hA5);
        expect_write(12'h346, 8'h3C);
        send_byte(8'hA5, ack); check("R5", ack, 0, "data ack 0");
        send_byte(8'h3C, ack); check("R5", ack, 0, "data ack 1");
        bus_stop();
        wait_clks(4);
        check("R5", exp_wq.size(), 0, "pending writes");
        check("R2", sda_oe, 0, "released after stop");
        ref_ptr = 12'h347;

        // Wrong device code stays silent (R3).
        we_before = we_count;
        bus_start();
        send_byte(8'h96, ack); check("R3", ack, 1, "foreign select nack");
        send_byte(8'h12, ack); check("R3", ack, 1, "silent after mismatch");
        bus_stop();
        check("R3", we_count, we_before, "no write on mismatch");

        // Random read of the two bytes (R7, R8, R9).
        bus_start();
        send_byte(8'hA6, ack);
        send_byte(8'h45, ack);
        bus_start();
        send_byte(8'hA7, ack); check("R7", ack, 0, "read select ack");
        recv_byte(rb, 1'b1); check("R7", rb, ref_mem[12'h345], "random read byte");
        recv_byte(rb, 1'b0); check("R8", rb, ref_mem[12'h346], "incremented read byte");
        wait_clks(4);
        check("R9", sda_oe, 0, "released after nack");
        for (int i = 0; i < 9; i++) begin
            get_bit(ack);
            check("R9", ack, 1, "silent clocks after nack");
        end
        bus_stop();

        // Current-address read ignores page bits (R6).
        bus_start();
        send_byte(8'hAF, ack); check("R6", ack, 0, "current read ack");
        recv_byte(rb, 1'b0); check("R6", rb, ref_mem[ref_ptr], "current-address byte");
        bus_stop();
        ref_ptr = ref_ptr + 1;

        // Write and read across 7FF -> 000 (R8).
        bus_start();
        send_byte(8'hAE, ack);
        send_byte(8'hFF, ack);
        expect_write(12'h7FF, 8'h11);
        expect_write(12'h000, 8'h22);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        bus_stop();
        wait_clks(4);
        check("R8", exp_wq.size(), 0, "wrap writes done");
        bus_start();
        send_byte(8'hAE, ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(8'hAF, ack);
        recv_byte(rb, 1'b1); check("R8", rb, 8'h11, "byte at 7FF");
        recv_byte(rb, 1'b0); check("R8", rb, 8'h22, "byte at 000 after wrap");
        bus_stop();

        // Repeated start inside a data byte abandons it (R1).
        we_before = we_count;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h10, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte(8'hA1, ack); check("R1", ack, 0, "select after restart");
        recv_byte(rb, 1'b0); check("R1", rb, ref_mem[12'h010], "pointer kept");
        bus_stop();
        check("R1", we_count, we_before, "no partial write");

        // Stop inside an address byte, then continue (R2).
        bus_start();
        send_byte(8'hA0, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_stop();
        wait_clks(4);
        check("R2", sda_oe, 0, "released after mid-byte stop");
        bus_start();
        send_byte(8'hA1, ack); check("R2", ack, 0, "select after stop");
        recv_byte(rb, 1'b0); check("R6", rb, ref_mem[12'h011], "read after stop");
        bus_stop();

        wait_clks(10);
        summary();
    end

endmodule